// File: doc/BRIEF.md
# Two-Wire Presence-Detect Memory Slave

This block is the slave side of a two-wire serial bus in front of a small byte-wide configuration store. A memory module uses such a store to describe itself to the host. The block samples the clock and data lines in its own clock domain and recognises start, repeated-start and stop conditions. It answers to one 7-bit device address. Bytes travel most significant bit first, and each byte is followed by a ninth acknowledge clock. The only output is an enable that pulls the open-drain data line low.

A word-address pointer stays valid from one transaction to the next. After any byte is read or written, the pointer holds that byte's address plus one and wraps at the top of the 256-byte array. A read that gives no address returns the byte at the pointer. To read an arbitrary byte, the host first issues a write that carries only a word address. It then sends a repeated start with a read request, and the block returns the byte at that address. The array takes computed contents at reset. A write can change one byte per transaction.

Top module: `spd_slave`

## Requirements
- R1: After reset the data line is released, the pointer is 0, and byte i holds (i*37 + 11) mod 256 (default parameters).
- R2: When the 8 bits after a start carry the device address (default 0x50) in bits 7..1, MSB first, with the read flag in bit 0 (1 = read), the block pulls the data line low for the ninth clock. It changes its pull only while SCL is low.
- R3: When the device address does not match, the block gives no acknowledge. It keeps the line released and leaves the pointer alone until the next start.
- R4: A read without a word address returns the byte at the pointer, MSB first, over the eight clocks that follow the address acknowledge.
- R5: In a write, the first byte after the device address is a word address. The block acknowledges it and loads the pointer with it. A repeated start followed by a read then returns the byte at that address.
- R6: The pointer advances by one after every byte read or written, and it wraps from 255 to 0.
- R7: If the host acknowledges a read byte, the block sends the next byte. If the host does not, the read ends and the line stays released.
- R8: The first data byte after the word address is stored at the pointer and acknowledged. Later bytes in the same write are not acknowledged and not stored.
- R9: A stop at any point returns the block to idle with the line released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired-AND of all drivers) |
| sda_pull_o | output | 1 | 1 pulls the data line low |

## Verification
The bench chains transactions so that each read's expected byte depends on the pointer value left by the previous one. A design that fails to persist, advance or wrap the pointer therefore returns the wrong byte. Random reads sweep the whole address space. A sequential read crosses address 255. A design that failed to load the pointer, or did not honour the host acknowledge, would return stale or missing bytes. Wrong device addresses are followed by clocked reads of the released line and then a pointer probe, which exposes a block that answers or moves its pointer when it should stay silent. A second data byte in one write must be refused and must leave the array intact. A stop before any word address must leave the pointer unchanged.

// File: rtl/spd_pkg.sv
package spd_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_DEV_ACK, ST_WADDR, ST_WADDR_ACK,
    ST_WDATA, ST_WDATA_ACK, ST_RDATA, ST_RACK
  } spd_state_e;
endpackage

// File: rtl/spd_sync.sv
module spd_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic rise_o,
  output logic fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] scl_pipe, sda_pipe;
  logic         scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[TOP-1:0], scl_i};
      sda_pipe <= {sda_pipe[TOP-1:0], sda_i};
      scl_q    <= scl_pipe[TOP];
      sda_q    <= sda_pipe[TOP];
    end
  end

  assign scl_o   = scl_pipe[TOP];
  assign sda_o   = sda_pipe[TOP];
  assign rise_o  = scl_o & ~scl_q;
  assign fall_o  = ~scl_o & scl_q;
  assign start_o = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o  = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/spd_mem.sv
module spd_mem #(
  parameter int ADDR_W   = 8,
  parameter int INIT_MUL = 37,
  parameter int INIT_ADD = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem[g] <= 8'((g * INIT_MUL + INIT_ADD) % 256);
      else if (we && (addr == ADDR_W'(g)))
        mem[g] <= wdata;
    end
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/spd_link.sv
module spd_link
  import spd_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h50,
  parameter int         ADDR_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              sda_s,
  input  logic [7:0]        rdata,
  output logic              pull_o,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              we_o,
  output logic [7:0]        wdata_o,
  output logic              ptr_load_o,
  output spd_state_e        st_o
);
  spd_state_e        st, st_n;
  logic [3:0]        cnt, cnt_n;
  logic [7:0]        sh, sh_n;
  logic              pull, pull_n, rw, rw_n, mack, mack_n;
  logic [ADDR_W-1:0] ptr, ptr_n;

  always_comb begin
    st_n = st; cnt_n = cnt; sh_n = sh; pull_n = pull;
    rw_n = rw; mack_n = mack; ptr_n = ptr;
    we_o = 1'b0; ptr_load_o = 1'b0;
    if (stop_evt) begin
      st_n = ST_IDLE; pull_n = 1'b0;
    end else if (start_evt) begin
      st_n = ST_DEV; cnt_n = '0; pull_n = 1'b0;
    end else begin
      case (st)
        ST_DEV, ST_WADDR, ST_WDATA: begin
          if (scl_rise && cnt != 4'd8) begin
            sh_n  = {sh[6:0], sda_s};
            cnt_n = cnt + 4'd1;
          end else if (scl_fall && cnt == 4'd8) begin
            if (st == ST_DEV) begin
              if (sh[7:1] == DEV_ADDR) begin
                pull_n = 1'b1; rw_n = sh[0]; st_n = ST_DEV_ACK;
              end else begin
                st_n = ST_IDLE;
              end
            end else if (st == ST_WADDR) begin
              ptr_n = sh[ADDR_W-1:0]; ptr_load_o = 1'b1;
              pull_n = 1'b1; st_n = ST_WADDR_ACK;
            end else begin
              we_o = 1'b1; ptr_n = ptr + 1'b1;
              pull_n = 1'b1; st_n = ST_WDATA_ACK;
            end
          end
        end
        ST_DEV_ACK: begin
          if (scl_fall) begin
            cnt_n = '0;
            if (rw) begin
              sh_n = rdata; pull_n = ~rdata[7]; st_n = ST_RDATA;
            end else begin
              pull_n = 1'b0; st_n = ST_WADDR;
            end
          end
        end
        ST_WADDR_ACK: begin
          if (scl_fall) begin
            pull_n = 1'b0; cnt_n = '0; st_n = ST_WDATA;
          end
        end
        ST_WDATA_ACK: begin
          if (scl_fall) begin
            pull_n = 1'b0; st_n = ST_IDLE;
          end
        end
        ST_RDATA: begin
          if (scl_rise) begin
            cnt_n = cnt + 4'd1;
          end else if (scl_fall) begin
            if (cnt == 4'd8) begin
              pull_n = 1'b0; ptr_n = ptr + 1'b1; st_n = ST_RACK;
            end else begin
              sh_n = {sh[6:0], 1'b0}; pull_n = ~sh[6];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack_n = ~sda_s;
          end else if (scl_fall) begin
            if (mack) begin
              sh_n = rdata; pull_n = ~rdata[7]; cnt_n = '0; st_n = ST_RDATA;
            end else begin
              st_n = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; cnt <= '0; sh <= '0; pull <= 1'b0;
      rw <= 1'b0; mack <= 1'b0; ptr <= '0;
    end else begin
      st <= st_n; cnt <= cnt_n; sh <= sh_n; pull <= pull_n;
      rw <= rw_n; mack <= mack_n; ptr <= ptr_n;
    end
  end

  assign pull_o  = pull;
  assign ptr_o   = ptr;
  assign wdata_o = sh;
  assign st_o    = st;
endmodule

// File: rtl/spd_slave.sv
module spd_slave #(
  parameter logic [6:0] DEV_ADDR    = 7'h50,
  parameter int         ADDR_W      = 8,
  parameter int         SYNC_STAGES = 2,
  parameter int         INIT_MUL    = 37,
  parameter int         INIT_ADD    = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_pull_o
);
  logic [1:0]          rst_pipe;
  logic                rst_sync_n;
  logic                scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic                we, ptr_load;
  logic [7:0]          wdata, rdata;
  logic [ADDR_W-1:0]   ptr;
  spd_pkg::spd_state_e link_st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  spd_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_o(scl_s), .sda_o(sda_s), .rise_o(scl_rise), .fall_o(scl_fall),
    .start_o(start_evt), .stop_o(stop_evt)
  );

  spd_link #(.DEV_ADDR(DEV_ADDR), .ADDR_W(ADDR_W)) u_link (
    .clk(clk), .rst_n(rst_sync_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt), .sda_s(sda_s), .rdata(rdata),
    .pull_o(sda_pull_o), .ptr_o(ptr), .we_o(we), .wdata_o(wdata),
    .ptr_load_o(ptr_load), .st_o(link_st)
  );

  spd_mem #(.ADDR_W(ADDR_W), .INIT_MUL(INIT_MUL), .INIT_ADD(INIT_ADD)) u_mem (
    .clk(clk), .rst_n(rst_sync_n), .we(we), .addr(ptr),
    .wdata(wdata), .rdata(rdata)
  );
endmodule

// File: rtl/spd_slave_chk.sv
module spd_slave_chk
  import spd_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_s,
  input logic              stop_evt,
  input logic              pull,
  input spd_state_e        st,
  input logic [ADDR_W-1:0] ptr,
  input logic              ptr_load
);
  // R2
  pull_stable_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s)) |-> $stable(pull));

  // R2
  pull_in_drive_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pull |-> (st inside {ST_DEV_ACK, ST_WADDR_ACK, ST_WDATA_ACK, ST_RDATA}));

  // R3
  idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !pull);

  // R6
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ptr != $past(ptr)) && !$past(ptr_load)) |-> (ptr == ADDR_W'($past(ptr) + 1'b1)));

  // R9
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (!pull && st == ST_IDLE));
endmodule

bind spd_slave spd_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .scl_s(scl_s), .stop_evt(stop_evt),
  .pull(sda_pull_o), .st(link_st), .ptr(ptr), .ptr_load(ptr_load)
);

// File: tb/spd_slave_tb.sv
module spd_slave_tb;
  localparam int         CLK_PERIOD = 10;
  localparam int         QP         = 6;
  localparam logic [6:0] DEV        = 7'h50;

  logic clk, rst_n, scl_m, sda_m;
  logic pull;
  logic line;
  int   checks, fails;
  logic [7:0] exp_mem [256];

  assign line = sda_m & ~pull;

  spd_slave u_dut (.clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(line), .sda_pull_o(pull));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic wq();
    repeat (QP) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic send_bit(logic b);
    sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
  endtask

  task automatic read_bit(output logic r);
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); r = line; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic send_byte(logic [7:0] b, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    read_bit(a);
    ack = ~a;
  endtask

  task automatic read_byte(logic host_ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) read_bit(d[i]);
    send_bit(~host_ack);
  endtask

  task automatic cur_read(string req, logic [7:0] exp);
    logic a; logic [7:0] d;
    bus_start();
    send_byte({DEV, 1'b1}, a);
    check("R2 read address ack", a, 1'b1);
    read_byte(1'b0, d);
    bus_stop();
    check(req, d, exp);
  endtask

  task automatic rand_read(logic [7:0] addr);
    logic a1, a2, a3; logic [7:0] d;
    bus_start();
    send_byte({DEV, 1'b0}, a1);
    send_byte(addr, a2);
    bus_start();
    send_byte({DEV, 1'b1}, a3);
    read_byte(1'b0, d);
    bus_stop();
    check("R5 random read acks", {a1, a2, a3}, 3'b111);
    check("R5 random read data", d, exp_mem[addr]);
  endtask

  initial begin
    checks = 0; fails = 0;
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic a, r; logic [7:0] d;
    for (int i = 0; i < 256; i++) exp_mem[i] = 8'((i * 37 + 11) % 256);
    scl_m = 1'b1; sda_m = 1'b1; rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    check("R1 line released after reset", pull, 1'b0);
    cur_read("R1 R4 first read returns byte 0", exp_mem[0]);
    cur_read("R6 pointer advanced to 1", exp_mem[1]);

    // R5 sweep over address space
    for (int k = 0; k < 16; k++) rand_read(8'(k * 17));
    cur_read("R6 wrap from 255 to 0", exp_mem[0]);

    // R7 sequential read across the top
    bus_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'd253, a);
    bus_start();
    send_byte({DEV, 1'b1}, a);
    for (int j = 0; j < 4; j++) begin
      read_byte(j != 3, d);
      check("R7 sequential byte", d, exp_mem[8'(253 + j)]);
    end
    bus_stop();
    check("R7 released after host nack", pull, 1'b0);
    cur_read("R7 R6 pointer after sequential read", exp_mem[1]);

    // R3 wrong device addresses
    foreach (exp_mem[i]) if (i < 1) ;
    for (int w = 0; w < 6; w++) begin
      logic [6:0] bad;
      bad = (w == 0) ? 7'h51 : (w == 1) ? 7'h10 : (w == 2) ? 7'h2F :
            (w == 3) ? 7'h58 : (w == 4) ? 7'h00 : 7'h7F;
      bus_start();
      send_byte({bad, 1'b1}, a);
      check("R3 no ack on mismatch", a, 1'b0);
      d = '0;
      for (int b = 7; b >= 0; b--) begin
        read_bit(r);
        d[b] = r;
      end
      check("R3 line stays released", d, 8'hFF);
      bus_stop();
    end
    cur_read("R3 pointer untouched by mismatch", exp_mem[2]);

    // R8 single byte write
    bus_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'h40, a);
    send_byte(8'hA5, a);
    check("R8 data byte acked", a, 1'b1);
    send_byte(8'h3C, a);
    check("R8 second byte refused", a, 1'b0);
    bus_stop();
    exp_mem[8'h40] = 8'hA5;
    cur_read("R8 R6 next byte unchanged", exp_mem[8'h41]);
    rand_read(8'h40);

    // R9 stop before a word address
    bus_start();
    send_byte({DEV, 1'b0}, a);
    bus_stop();
    check("R9 released after stop", line, 1'b1);
    cur_read("R9 pointer kept after early stop", exp_mem[8'h41]);

    // R5 word address then stop loads pointer
    bus_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'h10, a);
    bus_stop();
    cur_read("R5 pointer loaded by word address", exp_mem[8'h10]);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule